// File: doc/BRIEF.md
# Single-Channel DMA Controller with Selectable Triggers

This block is one DMA channel. Software sets it up through a small byte-wide register window. The window holds two control bytes, a source address, a destination address and a unit count. When a trigger arrives, the channel moves one 8-bit or 16-bit unit. It first reads the source over a simple request/acknowledge bus master port, then writes the captured data to the destination. After each unit, the source and destination addresses are each either held fixed or stepped by the unit size.

The trigger comes from a two-level selector. A 2-bit primary field picks one of three sources: a software start strobe, event input A or event input B. Its fourth code hands the choice to a 4-bit extended field. The extended field can pick a neighbouring channel's unit-completion pulse, which lets channels be chained, or one of nine further event inputs. A pending-request flag latches the trigger and holds it until the unit completes. Software can clear this flag but cannot set it.

In normal mode the channel disables itself when the count reaches zero. In ring mode it keeps running, and after every 32 units it returns both addresses to the values software last wrote. The `unit_done` output can drive the chaining input of another channel.

Top module: `dma_chan`

## Requirements
- R1: After reset every readable register (offsets 0 to 6) reads 0x00, and `m_req` and `unit_done` are low.
- R2: The pending flag is bit 1 of the control byte at offset 0, and it sets on a selected trigger. A write to offset 0 with bit 1 = 0 clears the flag, and a write with bit 1 = 1 leaves it unchanged. If a trigger occurs in the same cycle as a clearing write or a unit completion, the flag stays set.
- R3: Bits 3:2 of offset 0 select the trigger: 00 is `sw_start`, 01 is `ev_a`, 10 is `ev_b`, and 11 uses the extended field. Inputs that are not selected do not set the flag.
- R4: Bits 7:4 of offset 1 form the extended field. Code 0 selects `chain_in`, and code k (1 to 9) selects `ev_ext[k-1]`. Codes 10 to 15 never produce a trigger. Bits 3:0 of offset 1 always read 0.
- R5: A unit starts only from idle, and only when both the enable bit (bit 4 of offset 0) and the pending flag are 1. The unit is a read at the source address (`m_req`=1, `m_we`=0) held until `m_ack`. It is followed by a write (`m_we`=1) of the captured `m_rdata` to the destination address, also held until `m_ack`.
- R6: Bit 5 of offset 0 selects the unit size: 1 means 8 bits and drives `m_byte` high, 0 means 16 bits. The address step is 1 for 8-bit units and 2 for 16-bit units.
- R7: Bit 6 of offset 0 (source) and bit 7 (destination) choose whether each address increments (1) or stays fixed (0) after each unit. Offsets 2/3 give the source address low and high bytes, and 4/5 give the destination address. Reading them returns the current address. Writing them sets both the start value and the current address.
- R8: A unit completes on the write-phase `m_ack`, and `unit_done` pulses in that cycle. At completion the pending flag clears and the count at offset 6 decrements by one.
- R9: In normal mode (bit 0 of offset 0 = 0), a completion with a count of 1 clears the enable bit. A write to offset 0 in the same cycle takes precedence.
- R10: In ring mode (bit 0 = 1), the 32nd completion since reset or since the last address-register write returns both addresses to their start values instead of stepping them. The enable bit stays set.
- R11: `sw_start` has no effect unless bits 3:2 of offset 0 are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sw_start | input | 1 | Software start strobe |
| ev_a | input | 1 | Primary hardware event A |
| ev_b | input | 1 | Primary hardware event B |
| ev_ext | input | 9 | Extended event inputs |
| chain_in | input | 1 | Neighbour channel unit completion |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | Bus write (1) or read (0) |
| m_byte | output | 1 | Unit is 8 bits |
| m_addr | output | 16 | Bus address |
| m_wdata | output | 16 | Bus write data |
| m_rdata | input | 16 | Bus read data |
| m_ack | input | 1 | Bus acknowledge |
| unit_done | output | 1 | Pulse on unit completion |

## Verification
The hardest state to reach is the ring wrap. It only happens after 32 completed units in ring mode, with no address write in between. The bench therefore runs a dedicated sequence of 34 software-started units, and checks the addresses just before the wrap, at it and just after it. Same-cycle collisions are also hard to reach: a trigger coinciding with a unit completion or a clearing write, or a control write landing on the last counted unit. These are covered by a long phase of random event pulses and random register writes, with bus latency varying from 0 to 2 cycles. Throughout this phase, a behavioural model is compared with the design on every clock.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int CW       = 8,
  parameter int NEXT     = 9,
  parameter int RING_LEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            sw_start,
  input  logic            ev_a,
  input  logic            ev_b,
  input  logic [NEXT-1:0] ev_ext,
  input  logic            chain_in,
  output logic            m_req,
  output logic            m_we,
  output logic            m_byte,
  output logic [AW-1:0]   m_addr,
  output logic [DW-1:0]   m_wdata,
  input  logic [DW-1:0]   m_rdata,
  input  logic            m_ack,
  output logic            unit_done
);
  localparam int RW = $clog2(RING_LEN);
  localparam logic [RW-1:0] RING_LAST = RW'(RING_LEN - 1);
  localparam logic [2:0] A_CTL = 3'd0, A_EXT = 3'd1, A_SLO = 3'd2, A_SHI = 3'd3,
                         A_DLO = 3'd4, A_DHI = 3'd5, A_CNT = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic          ring, flag, en, bsz, sinc, dinc;
  logic [1:0]    sel;
  logic [3:0]    ext;
  logic [AW-1:0] src_base, dst_base, src, dst, step;
  logic [CW-1:0] cnt;
  logic [RW-1:0] ring_n;
  logic [DW-1:0] buf_q;
  logic          ext_hit, trig, wr_ctl, flag_clr;

  always_comb begin
    ext_hit = 1'b0;
    if (ext == 4'd0) ext_hit = chain_in;
    else
      for (int i = 0; i < NEXT; i++)
        if (int'(ext) == i + 1) ext_hit = ev_ext[i];
  end

  always_comb
    case (sel)
      2'd0:    trig = sw_start;
      2'd1:    trig = ev_a;
      2'd2:    trig = ev_b;
      default: trig = ext_hit;
    endcase

  assign wr_ctl    = reg_wr && reg_addr == A_CTL;
  assign flag_clr  = wr_ctl && !reg_wdata[1];
  assign step      = bsz ? AW'(1) : AW'(2);
  assign m_req     = st != S_IDLE;
  assign m_we      = st == S_WR;
  assign m_byte    = bsz;
  assign m_addr    = (st == S_WR) ? dst : src;
  assign m_wdata   = buf_q;
  assign unit_done = (st == S_WR) && m_ack;

  always_comb
    case (reg_addr)
      A_CTL:   reg_rdata = {dinc, sinc, bsz, en, sel, flag, ring};
      A_EXT:   reg_rdata = {ext, 4'b0000};
      A_SLO:   reg_rdata = src[7:0];
      A_SHI:   reg_rdata = 8'(src >> 8);
      A_DLO:   reg_rdata = dst[7:0];
      A_DHI:   reg_rdata = 8'(dst >> 8);
      A_CNT:   reg_rdata = 8'(cnt);
      default: reg_rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {ring, flag, en, bsz, sinc, dinc} <= '0;
      sel <= '0;
      ext <= '0;
      src_base <= '0;
      dst_base <= '0;
      src <= '0;
      dst <= '0;
      cnt <= '0;
      ring_n <= '0;
      buf_q <= '0;
    end else begin
      flag <= trig | (flag & ~flag_clr & ~unit_done);

      case (st)
        S_IDLE: if (en && flag) st <= S_RD;
        S_RD:   if (m_ack) begin buf_q <= m_rdata; st <= S_WR; end
        S_WR:   if (m_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

      if (unit_done) begin
        cnt <= cnt - CW'(1);
        if (ring && ring_n == RING_LAST) begin
          src <= src_base;
          dst <= dst_base;
          ring_n <= '0;
        end else begin
          if (sinc) src <= src + step;
          if (dinc) dst <= dst + step;
          if (ring) ring_n <= ring_n + RW'(1);
        end
        if (!ring && cnt == CW'(1)) en <= 1'b0;
      end

      if (reg_wr)
        case (reg_addr)
          A_CTL: begin
            ring <= reg_wdata[0];
            sel  <= reg_wdata[3:2];
            en   <= reg_wdata[4];
            bsz  <= reg_wdata[5];
            sinc <= reg_wdata[6];
            dinc <= reg_wdata[7];
          end
          A_EXT: ext <= reg_wdata[7:4];
          A_SLO: begin src_base[7:0] <= reg_wdata; src[7:0] <= reg_wdata; ring_n <= '0; end
          A_SHI: begin src_base[AW-1:8] <= reg_wdata[AW-9:0]; src[AW-1:8] <= reg_wdata[AW-9:0]; ring_n <= '0; end
          A_DLO: begin dst_base[7:0] <= reg_wdata; dst[7:0] <= reg_wdata; ring_n <= '0; end
          A_DHI: begin dst_base[AW-1:8] <= reg_wdata[AW-9:0]; dst[AW-1:8] <= reg_wdata[AW-9:0]; ring_n <= '0; end
          A_CNT: cnt <= reg_wdata[CW-1:0];
          default: ;
        endcase
    end
  end

  // R5: a bus request only rises when enable and pending flag were both set
  a_r5_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) |-> $past(en && flag));

  // R5: a phase without acknowledge keeps requesting in the same direction
  a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ack |=> m_req && $stable(m_we));

  // R8: completion with no new trigger leaves the flag clear
  a_r8_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && !trig |=> !flag);

  // R2: writing 1 to the flag bit never sets it
  a_r2_write_one: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && reg_wdata[1] && !flag && !trig |=> !flag);

  // R4: prohibited extended codes never trigger
  a_r4_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 2'd3 && int'(ext) > NEXT |-> !trig);

  // R9: last unit in normal mode disables the channel
  a_r9_normal_stop: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && !ring && cnt == CW'(1) && !wr_ctl |=> !en);

  // R10: ring mode keeps the channel enabled
  a_r10_ring_run: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && ring && en && !wr_ctl |=> en);
endmodule

// File: tb/tb_dma_chan.sv
module tb_dma_chan;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic sw_start = 1'b0, ev_a = 1'b0, ev_b = 1'b0, chain_in = 1'b0;
  logic [8:0] ev_ext = '0;
  logic m_req, m_we, m_byte, m_ack = 1'b0, unit_done;
  logic [15:0] m_addr, m_wdata, m_rdata;

  int checks = 0, fails = 0, cyc = 0, lat = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] rfn(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + 8'h3C};
  endfunction

  assign m_rdata = m_ack ? rfn(m_addr) : 16'h0000;

  dma_chan dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_start(sw_start),
    .ev_a(ev_a), .ev_b(ev_b), .ev_ext(ev_ext), .chain_in(chain_in),
    .m_req(m_req), .m_we(m_we), .m_byte(m_byte), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack), .unit_done(unit_done));

  // behavioural reference model
  logic mmd, mfl, men, mbs, msi, mdi;
  logic [1:0] msl;
  logic [3:0] mex;
  logic [15:0] msb, mdb, msa, mda, mbf;
  logic [7:0] mcn;
  int mrn, mst, units;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {mmd, mfl, men, mbs, msi, mdi} = '0;
      msl = 0; mex = 0; msb = 0; mdb = 0; msa = 0; mda = 0; mbf = 0; mcn = 0;
      mrn = 0; mst = 0; units = 0;
    end else begin
      logic t, done, clr;
      logic [15:0] stp;
      case (msl)
        2'd0: t = sw_start;
        2'd1: t = ev_a;
        2'd2: t = ev_b;
        default: t = (mex == 0) ? chain_in : (mex <= 9) ? ev_ext[int'(mex) - 1] : 1'b0;
      endcase
      done = (mst == 2) && m_ack;
      clr  = reg_wr && reg_addr == 0 && !reg_wdata[1];
      stp  = mbs ? 16'd1 : 16'd2;
      case (mst)
        0: if (men && mfl) mst = 1;
        1: if (m_ack) begin mbf = rfn(msa); mst = 2; end
        default: if (m_ack) mst = 0;
      endcase
      mfl = t || (mfl && !clr && !done);
      if (done) begin
        units++;
        if (!mmd && mcn == 1) men = 0;
        mcn = mcn - 1;
        if (mmd && mrn == 31) begin msa = msb; mda = mdb; mrn = 0; end
        else begin
          if (msi) msa = msa + stp;
          if (mdi) mda = mda + stp;
          if (mmd) mrn++;
        end
      end
      if (reg_wr)
        case (reg_addr)
          0: begin mmd = reg_wdata[0]; msl = reg_wdata[3:2]; men = reg_wdata[4];
                   mbs = reg_wdata[5]; msi = reg_wdata[6]; mdi = reg_wdata[7]; end
          1: mex = reg_wdata[7:4];
          2: begin msb[7:0] = reg_wdata; msa[7:0] = reg_wdata; mrn = 0; end
          3: begin msb[15:8] = reg_wdata; msa[15:8] = reg_wdata; mrn = 0; end
          4: begin mdb[7:0] = reg_wdata; mda[7:0] = reg_wdata; mrn = 0; end
          5: begin mdb[15:8] = reg_wdata; mda[15:8] = reg_wdata; mrn = 0; end
          6: mcn = reg_wdata;
          default: ;
        endcase
    end
  end

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, got, exp);
    end
  endtask

  function automatic logic [7:0] mread(input logic [2:0] a);
    case (a)
      0: return {mdi, msi, mbs, men, msl, mfl, mmd};
      1: return {mex, 4'b0000};
      2: return msa[7:0];
      3: return msa[15:8];
      4: return mda[7:0];
      5: return mda[15:8];
      6: return mcn;
      default: return 8'h00;
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    string rt;
    cyc++;
    check({15'd0, m_req}, {15'd0, mst != 0}, "R5 m_req");
    check({15'd0, unit_done}, {15'd0, mst == 2 && m_ack}, "R8 unit_done");
    check({15'd0, m_byte}, {15'd0, mbs}, "R6 m_byte");
    if (mst != 0) begin
      check({15'd0, m_we}, {15'd0, mst == 2}, "R5 m_we");
      check(m_addr, (mst == 2) ? mda : msa, "R7 m_addr");
    end
    if (mst == 2) check(m_wdata, mbf, "R5 m_wdata");
    case (reg_addr)
      0: rt = "R2 ctrl";
      1: rt = "R4 ext";
      6: rt = "R8 count";
      default: rt = "R7 address";
    endcase
    if (!rst_n) rt = "R1 reset";
    check({8'd0, reg_rdata}, {8'd0, mread(reg_addr)}, rt);
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // bus responder with 0..2 cycle latency
  always @(negedge clk) begin
    #1;
    if (m_req && lat == 0 && !m_ack) begin
      m_ack = 1'b1;
      lat = $urandom % 3;
    end else begin
      m_ack = 1'b0;
      if (m_req && lat > 0) lat--;
    end
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    tick(); reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick(); reg_wr = 0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
    tick(); reg_addr = a; #1;
    check({8'd0, reg_rdata}, {8'd0, e}, tag);
  endtask

  task automatic pulse_sw(); tick(); sw_start = 1; tick(); sw_start = 0; endtask

  task automatic wait_unit();
    int u0 = units;
    for (int i = 0; i < 40 && units == u0; i++) tick();
    tick();
  endtask

  task automatic set_addrs(input logic [15:0] s, input logic [15:0] d);
    wr(2, s[7:0]); wr(3, s[15:8]); wr(4, d[7:0]); wr(5, d[15:8]);
  endtask

  initial begin
    repeat (3) tick();
    for (int a = 0; a < 7; a++) expect_reg(3'(a), 8'h00, "R1 reset value");
    rst_n = 1;
    tick();
    for (int a = 0; a < 7; a++) expect_reg(3'(a), 8'h00, "R1 after release");

    // normal mode, 16-bit, both incrementing, software start
    set_addrs(16'h0100, 16'h0200); wr(6, 8'd3); wr(0, 8'hD0);
    repeat (3) begin pulse_sw(); wait_unit(); end
    expect_reg(2, 8'h06, "R6 R7 src step 2");
    expect_reg(4, 8'h06, "R7 dst step 2");
    expect_reg(6, 8'h00, "R8 count to zero");
    expect_reg(0, 8'hC0, "R9 enable cleared");
    pulse_sw(); repeat (6) tick();
    expect_reg(0, 8'hC2, "R5 no unit while disabled");

    // flag write semantics
    wr(0, 8'h00); pulse_sw();
    expect_reg(0, 8'h02, "R2 flag set by trigger");
    wr(0, 8'h02);
    expect_reg(0, 8'h02, "R2 write one keeps flag");
    wr(0, 8'h00);
    expect_reg(0, 8'h00, "R2 write zero clears");

    // event A, 8-bit, src fixed, dst incrementing
    set_addrs(16'h0400, 16'h0500); wr(6, 8'd2); wr(0, 8'hB4);
    pulse_sw(); repeat (4) tick();
    expect_reg(0, 8'hB4, "R11 sw_start ignored");
    tick(); ev_b = 1; tick(); ev_b = 0; repeat (4) tick();
    expect_reg(0, 8'hB4, "R3 ev_b ignored under select 01");
    tick(); ev_a = 1; tick(); ev_a = 0; wait_unit();
    expect_reg(2, 8'h00, "R7 src fixed");
    expect_reg(4, 8'h01, "R6 dst step 1");
    wr(0, 8'hB8);
    tick(); ev_b = 1; tick(); ev_b = 0; wait_unit();
    expect_reg(4, 8'h02, "R3 ev_b selected");
    expect_reg(0, 8'hA8, "R9 enable cleared at count zero");

    // extended selector, channel disabled so flags accumulate
    wr(1, 8'hFF);
    expect_reg(1, 8'hF0, "R4 low nibble reads zero");
    for (int k = 0; k < 16; k++) begin
      wr(0, 8'h0C); wr(1, 8'(k << 4));
      tick(); sw_start = 1; ev_a = 1; ev_b = 1;
      if (k >= 1 && k <= 9) begin ev_ext = '1; ev_ext[k-1] = 0; chain_in = 1; end
      else if (k == 0) ev_ext = '1;
      else begin ev_ext = '1; chain_in = 1; end
      tick(); {sw_start, ev_a, ev_b, chain_in} = '0; ev_ext = '0;
      expect_reg(0, 8'h0C, "R4 non-selected inputs");
      tick();
      if (k == 0) chain_in = 1; else if (k <= 9) ev_ext[k-1] = 1;
      tick(); chain_in = 0; ev_ext = '0;
      expect_reg(0, (k <= 9) ? 8'h0E : 8'h0C, "R4 selected code");
    end

    // ring mode, 8-bit, both incrementing, count wraps
    wr(0, 8'h00); set_addrs(16'h0300, 16'h0600); wr(6, 8'd5); wr(0, 8'hF1);
    for (int u = 0; u < 34; u++) begin
      pulse_sw(); wait_unit();
      if (u == 30) expect_reg(2, 8'h1F, "R10 src before wrap");
      if (u == 31) begin
        expect_reg(2, 8'h00, "R10 src wrapped");
        expect_reg(4, 8'h00, "R10 dst wrapped");
        expect_reg(0, 8'hF1, "R10 enable kept");
      end
    end
    expect_reg(2, 8'h02, "R10 after wrap");
    expect_reg(6, 8'(5 - 34), "R8 count wraps in ring mode");

    // random collisions
    for (int i = 0; i < 5000; i++) begin
      tick();
      sw_start = ($urandom % 6) == 0;
      ev_a = ($urandom % 6) == 0;
      ev_b = ($urandom % 6) == 0;
      chain_in = ($urandom % 6) == 0;
      ev_ext = 9'($urandom) & 9'($urandom);
      reg_addr = 3'($urandom);
      reg_wdata = 8'($urandom);
      reg_wr = ($urandom % 10) == 0;
      if (reg_wr && reg_addr == 0 && ($urandom % 2)) reg_wdata[4] = 1;
    end
    tick(); {reg_wr, sw_start, ev_a, ev_b, chain_in} = '0; ev_ext = '0;
    repeat (10) tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule